// File: doc/BRIEF.md
# Edge-Flagged General-Purpose I/O Port

An eight-pin general-purpose I/O port reached through a small byte-wide register bus. Software chooses a direction for each pin. Pins set as outputs carry the value held in the data register. A read of the data register returns, bit by bit, either the stored value (output pins) or the pin level after synchronization (input pins).

Four pin positions (7, 6, 1 and 0) can also catch edges. Each of these pins has its own polarity bit, which picks a rising or a falling edge as the event. An event latches a sticky flag, and software clears the flag by writing a one to it. An enable mask decides which flags reach a single level-sensitive interrupt line. That line stays asserted until the enabled flags are cleared.

Top module: `gpio_edge_port`

## Requirements
- R1: While reset is asserted, every register reads zero, `pin_oe` and `pin_out` are zero, and `irq` is low.
- R2: `pin_oe` equals the direction register and `pin_out` equals the data register, bit for bit.
- R3: A read at offset 0 returns, for each bit, the stored data bit where the direction bit is 1. Where the direction bit is 0 it returns `pin_in` through a two-flop synchronizer, so a pin change shows after the second rising clock edge.
- R4: Only flag positions 7, 6, 1 and 0 exist. Bits 5 to 2 of the flag register (offset 4) always read 0, whatever the writes or pin edges.
- R5: A flag is set one clock edge after the synchronized pin differs from its previous sample in the active direction. Polarity bit 1 (offset 2) selects rising and 0 selects falling.
- R6: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged.
- R7: If an active edge and a clearing write reach the same flag in the same cycle, the flag ends set.
- R8: `irq` is the OR of (flag AND enable, offset 3), registered, so it follows the flags one cycle later.
- R9: The map is offset 0 data, 1 direction, 2 polarity, 3 enable, 4 flags. Every register is readable and writable at any time. Offsets 5 to 7 read 0 and ignore writes. `bus_rdata` is 0 when no read is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| pin_in | input | 8 | Pin levels, asynchronous |
| pin_out | output | 8 | Output levels |
| pin_oe | output | 8 | Output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The readback property compares input bits against `pin_in` from two cycles earlier. It therefore assumes the pins were low through reset and for two cycles after it, which the stimulus respects by changing pins only once reset has been released for several cycles. The flag properties assume that no other agent alters the flags, so any fall in a flag must come from a write at offset 4. Random bus traffic is skewed toward the flag and control offsets, and pins toggle with low probability. This lets edges, clears and their collisions occur often while every pin level still crosses the synchronizer.

// File: rtl/gpio_edge_port.sv
module gpio_edge_port #(
  parameter int W = 8,
  parameter int AW = 3,
  parameter logic [W-1:0] FLAG_MASK = 8'hC3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic          irq
);
  localparam logic [AW-1:0] A_DATA = AW'(0);
  localparam logic [AW-1:0] A_DIR  = AW'(1);
  localparam logic [AW-1:0] A_POL  = AW'(2);
  localparam logic [AW-1:0] A_IEN  = AW'(3);
  localparam logic [AW-1:0] A_FLAG = AW'(4);

  logic [W-1:0] data_q, dir_q, pol_q, ien_q, flag_q;
  logic [W-1:0] sync1_q, sync2_q, prev_q;
  logic         irq_q;
  logic [W-1:0] hit, clr;
  logic         wr_en;

  assign wr_en = bus_sel & bus_wr;
  assign hit = FLAG_MASK & ((pol_q & sync2_q & ~prev_q) | (~pol_q & ~sync2_q & prev_q));
  assign clr = (wr_en && bus_addr == A_FLAG) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      dir_q   <= '0;
      pol_q   <= '0;
      ien_q   <= '0;
      flag_q  <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      if (wr_en) begin
        case (bus_addr)
          A_DATA:  data_q <= bus_wdata;
          A_DIR:   dir_q  <= bus_wdata;
          A_POL:   pol_q  <= bus_wdata;
          A_IEN:   ien_q  <= bus_wdata;
          default: ;
        endcase
      end
      flag_q <= (flag_q & ~clr) | hit;
      irq_q  <= |(flag_q & ien_q);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        A_DATA:  bus_rdata = (dir_q & data_q) | (~dir_q & sync2_q);
        A_DIR:   bus_rdata = dir_q;
        A_POL:   bus_rdata = pol_q;
        A_IEN:   bus_rdata = ien_q;
        A_FLAG:  bus_rdata = flag_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign pin_out = data_q;
  assign pin_oe  = dir_q;
  assign irq     = irq_q;
endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk #(
  parameter int W = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [W-1:0]  bus_rdata,
  input logic [W-1:0]  pin_in,
  input logic          irq,
  input logic [W-1:0]  dir,
  input logic [W-1:0]  ien,
  input logic [W-1:0]  flag,
  input logic [W-1:0]  hit
);
  assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(|(flag & ien)));

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && bus_addr == AW'(4)) |=> ((flag & $past(flag)) == $past(flag)));

  assert_edge_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((flag & $past(hit)) == $past(hit)));

  assert_input_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == AW'(0)) |-> (((bus_rdata ^ $past(pin_in, 2)) & ~dir) == '0));

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr > AW'(4)) |-> (bus_rdata == '0));

  assert_idle_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |-> (bus_rdata == '0));
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .pin_in(pin_in), .irq(irq),
  .dir(dir_q), .ien(ien_q), .flag(flag_q), .hit(hit)
);

// File: tb/test_gpio_edge_port.sv
`timescale 1ns/1ps
module test_gpio_edge_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, pin_in = '0;
  logic [7:0] bus_rdata, pin_out, pin_oe;
  logic       irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_edge_port i_gpio_edge_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // reference state, built from the requirements
  localparam logic [7:0] FLAGS = 8'hC3;
  logic [7:0] m_data, m_dir, m_pol, m_ien, m_flag, m_s1, m_s2, m_prev;
  logic       m_irq;

  function automatic logic [7:0] edges(input logic [7:0] pol, cur, old);
    return FLAGS & ((pol & cur & ~old) | (~pol & ~cur & old));
  endfunction

  function automatic logic [7:0] exp_read(input logic sel, wr, input logic [2:0] a);
    if (!sel || wr) return 8'h00;
    case (a)
      3'd0: return (m_dir & m_data) | (~m_dir & m_s2);
      3'd1: return m_dir;
      3'd2: return m_pol;
      3'd3: return m_ien;
      3'd4: return m_flag;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_data <= 0; m_dir <= 0; m_pol <= 0; m_ien <= 0; m_flag <= 0;
      m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_irq <= 0;
    end else begin
      m_s1 <= pin_in; m_s2 <= m_s1; m_prev <= m_s2;
      if (bus_sel && bus_wr) begin
        if (bus_addr == 3'd0) m_data <= bus_wdata;
        if (bus_addr == 3'd1) m_dir  <= bus_wdata;
        if (bus_addr == 3'd2) m_pol  <= bus_wdata;
        if (bus_addr == 3'd3) m_ien  <= bus_wdata;
      end
      m_flag <= (m_flag & ~((bus_sel && bus_wr && bus_addr == 3'd4) ? bus_wdata : 8'h00))
                | edges(m_pol, m_s2, m_prev);
      m_irq <= |(m_flag & m_ien);
    end
  end

  task automatic check(input string req, input logic [7:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    string t;
    check("R2 pin_oe", pin_oe, m_dir);
    check("R2 pin_out", pin_out, m_data);
    check("R8 irq", {7'd0, irq}, {7'd0, m_irq});
    if (!bus_sel || bus_wr) t = "R9 idle";
    else if (bus_addr == 3'd0) t = "R3 data";
    else if (bus_addr == 3'd4) t = "R6 flags";
    else t = "R9 map";
    check(t, bus_rdata, exp_read(bus_sel, bus_wr, bus_addr));
  endtask

  task automatic step(input logic s, w, input logic [2:0] a, input logic [7:0] d, p);
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d; pin_in = p;
    @(negedge clk);
    compare_all();
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] p);
    step(1, 0, a, 8'h00, p);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] p;
    process::self().srandom(32'h5eed_1234);
    // R1: reset state
    @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      bus_sel = 1; bus_wr = 0; bus_addr = 3'(a);
      #0.5;
      check("R1 reset read", bus_rdata, 8'h00);
    end
    check("R1 reset oe", pin_oe, 8'h00);
    check("R1 reset irq", {7'd0, irq}, 8'h00);
    @(negedge clk); rst_n = 1;
    repeat (3) step(0, 0, 0, 0, 8'h00);

    // R7: edge and clear in the same cycle
    step(1, 1, 3'd2, 8'h01, 8'h00);
    step(1, 1, 3'd3, 8'h01, 8'h00);
    step(0, 0, 0, 0, 8'h01);
    step(0, 0, 0, 0, 8'h01);
    step(1, 1, 3'd4, 8'h01, 8'h01);
    rd(3'd4, 8'h01);
    check("R7 collision keeps flag", bus_rdata, 8'h01);
    check("R8 irq raised", {7'd0, irq}, 8'h01);
    step(1, 1, 3'd4, 8'h01, 8'h01);
    rd(3'd4, 8'h01);
    check("R6 clear", bus_rdata, 8'h00);
    check("R8 irq dropped", {7'd0, irq}, 8'h00);

    // R4: no flags at positions 5..2
    step(1, 1, 3'd2, 8'hFF, 8'h01);
    step(1, 1, 3'd4, 8'h3C, 8'h3D);
    repeat (3) step(0, 0, 0, 0, 8'h3D);
    rd(3'd4, 8'h3D);
    check("R4 reserved flags", bus_rdata, 8'h00);

    // R5: polarity, bit 7 falling only
    step(1, 1, 3'd2, 8'h7F, 8'h3D);
    repeat (3) step(0, 0, 0, 0, 8'hBD);
    rd(3'd4, 8'hBD);
    check("R5 rising ignored on falling pol", bus_rdata, 8'h00);
    repeat (3) step(0, 0, 0, 0, 8'h3D);
    rd(3'd4, 8'h3D);
    check("R5 falling edge sets flag", bus_rdata, 8'h80);
    step(1, 1, 3'd4, 8'h00, 8'h3D);
    rd(3'd4, 8'h3D);
    check("R6 zero write keeps", bus_rdata, 8'h80);
    step(1, 1, 3'd4, 8'h80, 8'h3D);
    rd(3'd4, 8'h3D);
    check("R6 one write clears", bus_rdata, 8'h00);

    // R3 / R2: mixed direction readback
    step(1, 1, 3'd1, 8'h0F, 8'h3D);
    step(1, 1, 3'd0, 8'hAA, 8'h3D);
    rd(3'd0, 8'h3D);
    check("R3 mixed readback", bus_rdata, 8'h3A);
    check("R2 oe", pin_oe, 8'h0F);
    check("R2 out", pin_out, 8'hAA);

    // R9: unmapped write ignored, reads zero
    step(1, 1, 3'd6, 8'h55, 8'h3D);
    rd(3'd6, 8'h3D);
    check("R9 unmapped", bus_rdata, 8'h00);
    rd(3'd1, 8'h3D);
    check("R9 dir intact", bus_rdata, 8'h0F);

    // random traffic
    p = 8'h3D;
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] a;
      a = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7)) : 3'($urandom_range(0, 4));
      if ($urandom_range(0, 3) == 0) p = p ^ 8'($urandom_range(0, 255));
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, 8'($urandom_range(0, 255)), p);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule